// File: doc/BRIEF.md
# Bridge-Sensor Converter Readout Sequencer

This block sits on the host side of a two-wire link to a delta-sigma converter. The converter has one serial clock input and one shared output pin. That pin first signals "result ready" by going low, and then carries the result bits. The sequencer waits for the ready indication on a synchronized copy of the pin. It then drives serial clock pulses whose high and low phases are each a fixed number of system cycles. It samples a data bit at the end of every high phase and assembles a 20-bit two's-complement result, which it sign-extends to the output width.

One command selects the frame length. A plain read uses 20 pulses. A force-high read adds one pulse so the shared pin returns high. A full read uses 24 pulses. A calibration request uses 26 pulses and then waits until the pin falls again, without reporting a result. Two further commands park the serial clock high to put the converter in standby, and wake it up again.

After an input-change notification, the sequencer drops a programmable number of completed readings before it reports one. A calibration or a wake-up cancels any drops still pending, because the converter's first result after either one is already settled. If the ready indication does not arrive within a programmable number of cycles, a timeout flag is raised.

Top module: `conv_readout_seq`

## Requirements
- R1: After a read or calibration command, no serial clock rising edge is issued until the synchronized data pin has been seen low.
- R2: Within a frame, every serial clock high phase and every low phase between two pulses lasts exactly HALF_CYC system cycles.
- R3: Bits are captured MSB first at the end of each of the first 20 high phases. The reported result is the 20-bit two's-complement value, sign-extended to OUT_W bits.
- R4: cmd_op encodes the frame length as 0 = 20 pulses, 1 = 21, 2 = 24 and 3 = 26.
- R5: A 26-pulse frame reports no result. busy stays high after the last pulse until the synchronized pin goes low.
- R6: A cycle with mux_changed high loads drop_count into the drop counter, and this load wins over a decrement in the same cycle. While the counter is non-zero, each completed read frame decrements it and raises no result_valid.
- R7: The end of a 26-pulse frame and an accepted wake command both clear the drop counter.
- R8: cmd_op 4 in idle parks the serial clock high from the next cycle, with busy low. While parked, only cmd_op 5 (wake) is accepted, and it drives the serial clock low and returns the block to idle.
- R9: If the pin is not seen low within TIMEOUT_CYC cycles of waiting, timeout_err is set and busy drops. The next accepted read or calibration command clears the flag.
- R10: Commands are accepted only in idle. busy is high from the cycle after acceptance until the frame ends, and result_valid is a one-cycle pulse in the first cycle after busy falls.
- R11: Reset leaves the serial clock low, with busy, result_valid and timeout_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..3 frames, 4 standby, 5 wake) |
| mux_changed | input | 1 | Input-change notification, loads the drop counter |
| drop_count | input | DROP_W | Number of readings to drop after an input change |
| sdo_in | input | 1 | Shared ready/data pin from the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame in progress |
| result | output | OUT_W | Sign-extended result |
| result_valid | output | 1 | One-cycle result strobe |
| timeout_err | output | 1 | Ready not seen in time |

## Verification
The bench drives a behavioural converter that changes the pin a fixed delay after each rising edge. It checks the pulse count of every frame length, and it checks negative results and the all-ones code. A design that sampled too early, in the wrong bit order or without sign extension would report a wrong word. A wrong frame length shows up as a wrong pulse count.

Other tests target ordering. In one, a read is held back while the pin stays high. In another, a command is issued in the middle of a frame and must be ignored. The drop sequence must report only on its fifth read. A calibration must hold busy until the pin falls and must cancel the pending drops.

Standby must ignore a read while parked, and the bench also forces a timeout. A design that failed any of these would clock too early, lengthen a frame, report a dropped reading, or leave the serial clock or busy in the wrong state.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
   localparam int DATA_W = 20;
   localparam int IDX_W  = 5;

   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_FORCE = 3'd1,
      OP_FULL  = 3'd2,
      OP_CAL   = 3'd3,
      OP_SLEEP = 3'd4,
      OP_WAKE  = 3'd5
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT,
      S_HI,
      S_LO,
      S_CALW,
      S_PARK
   } st_e;

   localparam logic [IDX_W-1:0] CAL_LEN = 5'd26;

   function automatic logic [IDX_W-1:0] frame_len(input logic [2:0] op);
      case (op)
         3'd0:    return 5'd20;
         3'd1:    return 5'd21;
         3'd2:    return 5'd24;
         default: return CAL_LEN;
      endcase
   endfunction
endpackage

// File: rtl/rdseq_sync.sv
module rdseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '1;
      else        ff_q <= {ff_q[STAGES-2:0], d};
   end

   assign q = ff_q[STAGES-1];
endmodule

// File: rtl/rdseq_shift.sv
module rdseq_shift #(
   parameter int DW    = 20,
   parameter int OUT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [OUT_W-1:0] word
);
   logic [DW-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr_q <= '0;
      else if (clr)      sr_q <= '0;
      else if (shift_en) sr_q <= {sr_q[DW-2:0], bit_in};
   end

   if (OUT_W > DW) begin : g_ext
      assign word = {{(OUT_W-DW){sr_q[DW-1]}}, sr_q};
   end else begin : g_same
      assign word = sr_q[OUT_W-1:0];
   end
endmodule

// File: rtl/rdseq_drop.sv
module rdseq_drop #(
   parameter int DROP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DROP_W-1:0] load_val,
   input  logic              clear,
   input  logic              consume,
   output logic              pending
);
   logic [DROP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load)              cnt_q <= load_val;
      else if (clear)             cnt_q <= '0;
      else if (consume && pending) cnt_q <= cnt_q - 1'b1;
   end

   assign pending = (cnt_q != '0);
endmodule

// File: rtl/conv_readout_seq.sv
module conv_readout_seq
   import rdseq_pkg::*;
#(
   parameter int OUT_W       = 32,
   parameter int HALF_CYC    = 5,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 1000000,
   parameter int DROP_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic              mux_changed,
   input  logic [DROP_W-1:0] drop_count,
   input  logic              sdo_in,
   output logic              sclk,
   output logic              busy,
   output logic [OUT_W-1:0]  result,
   output logic              result_valid,
   output logic              timeout_err
);
   localparam int HC_W = $clog2(HALF_CYC + 1);
   localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

   if (OUT_W < DATA_W) begin : g_bad_width
      $error("OUT_W must be at least the result width");
   end
   if (HALF_CYC < SYNC_STAGES + 1) begin : g_bad_half
      $error("HALF_CYC too short for sampling after the synchronizer");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("TIMEOUT_CYC must be at least 2");
   end

   st_e              st_q;
   logic [HC_W-1:0]  hc_q;
   logic [TO_W-1:0]  to_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] len_q;
   logic             sclk_q, err_q, val_q;
   logic [OUT_W-1:0] res_q;
   logic             sdo_s;
   logic [OUT_W-1:0] word;
   logic             pending;

   logic half_done, to_done, accept_rd, shift_en, frame_end, wake_ok;

   assign half_done = (hc_q == HC_W'(HALF_CYC - 1));
   assign to_done   = (to_q == TO_W'(TIMEOUT_CYC - 1));
   assign accept_rd = (st_q == S_IDLE) && cmd_valid && (cmd_op <= OP_CAL);
   assign wake_ok   = (st_q == S_PARK) && cmd_valid && (cmd_op == OP_WAKE);
   assign shift_en  = (st_q == S_HI) && half_done && (idx_q < IDX_W'(DATA_W));
   assign frame_end = (st_q == S_LO) && half_done && (idx_q == len_q - 5'd1);

   rdseq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(sdo_in), .q(sdo_s));

   rdseq_shift #(.DW(DATA_W), .OUT_W(OUT_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .clr(accept_rd), .shift_en(shift_en),
      .bit_in(sdo_s), .word(word));

   rdseq_drop #(.DROP_W(DROP_W)) i_drop (
      .clk(clk), .rst_n(rst_n), .load(mux_changed), .load_val(drop_count),
      .clear((frame_end && len_q == CAL_LEN) || wake_ok),
      .consume(frame_end && len_q != CAL_LEN), .pending(pending));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         hc_q   <= '0;
         to_q   <= '0;
         idx_q  <= '0;
         len_q  <= '0;
         sclk_q <= 1'b0;
         err_q  <= 1'b0;
         val_q  <= 1'b0;
         res_q  <= '0;
      end else begin
         val_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (accept_rd) begin
                  st_q  <= S_WAIT;
                  len_q <= frame_len(cmd_op);
                  to_q  <= '0;
                  err_q <= 1'b0;
               end else if (cmd_valid && cmd_op == OP_SLEEP) begin
                  st_q   <= S_PARK;
                  sclk_q <= 1'b1;
               end
            end
            S_WAIT: begin
               if (!sdo_s) begin
                  st_q   <= S_HI;
                  sclk_q <= 1'b1;
                  hc_q   <= '0;
                  idx_q  <= '0;
               end else if (to_done) begin
                  err_q <= 1'b1;
                  st_q  <= S_IDLE;
               end else begin
                  to_q <= to_q + 1'b1;
               end
            end
            S_HI: begin
               if (half_done) begin
                  hc_q   <= '0;
                  sclk_q <= 1'b0;
                  st_q   <= S_LO;
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            S_LO: begin
               if (half_done) begin
                  hc_q <= '0;
                  if (frame_end) begin
                     if (len_q == CAL_LEN) begin
                        st_q <= S_CALW;
                        to_q <= '0;
                     end else begin
                        st_q <= S_IDLE;
                        if (!pending) begin
                           val_q <= 1'b1;
                           res_q <= word;
                        end
                     end
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     sclk_q <= 1'b1;
                     st_q   <= S_HI;
                  end
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            S_CALW: begin
               if (!sdo_s) begin
                  st_q <= S_IDLE;
               end else if (to_done) begin
                  err_q <= 1'b1;
                  st_q  <= S_IDLE;
               end else begin
                  to_q <= to_q + 1'b1;
               end
            end
            S_PARK: begin
               if (wake_ok) begin
                  sclk_q <= 1'b0;
                  st_q   <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign sclk         = sclk_q;
   assign busy         = (st_q != S_IDLE) && (st_q != S_PARK);
   assign result       = res_q;
   assign result_valid = val_q;
   assign timeout_err  = err_q;
endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
   parameter int OUT_W    = 32,
   parameter int HALF_CYC = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             sclk,
   input logic             busy,
   input logic [OUT_W-1:0] result,
   input logic             result_valid,
   input logic             timeout_err
);
   localparam int DW = 20;
   logic        sclk_d;
   logic [15:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         ph     <= '0;
      end else begin
         sclk_d <= sclk;
         if (sclk != sclk_d)  ph <= 16'd1;
         else if (ph != '1)   ph <= ph + 16'd1;
      end
   end

   assert_sclk_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_d && !sclk && busy) |-> (ph == 16'(HALF_CYC)));

   assert_valid_after_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (!busy && $past(busy)));

   assert_park_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && !busy && !(cmd_valid && cmd_op == 3'd5)) |=> sclk);

   assert_timeout_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_err) |-> (!busy && $past(busy)));

   assert_sign_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> ((result[OUT_W-1:DW-1] == '0) || (result[OUT_W-1:DW-1] == '1)));
endmodule

bind conv_readout_seq rdseq_chk #(.OUT_W(OUT_W), .HALF_CYC(HALF_CYC)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .sclk(sclk), .busy(busy), .result(result), .result_valid(result_valid),
   .timeout_err(timeout_err));

// File: tb/test_conv_readout_seq.sv
module test_conv_readout_seq;
   localparam int CLK_PERIOD = 20;
   localparam int OUT_W      = 32;
   localparam int HALF       = 5;
   localparam int TMO        = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic        mux_changed = 1'b0;
   logic [3:0]  drop_count = 4'd0;
   logic        pin = 1'b1;
   logic        sclk, busy, result_valid, timeout_err;
   logic [OUT_W-1:0] result;

   int checks = 0, fails = 0;
   int rises = 0, got_valid = 0, ph = 0;
   logic [OUT_W-1:0] got_result = '0;
   logic sclk_prev = 1'b0, low_in_frame = 1'b0;
   logic [19:0] dev_word = '0;
   int dev_idx = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_readout_seq #(.OUT_W(OUT_W), .HALF_CYC(HALF), .SYNC_STAGES(2),
                      .TIMEOUT_CYC(TMO), .DROP_W(4)) i_conv_readout_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .mux_changed(mux_changed), .drop_count(drop_count), .sdo_in(pin),
      .sclk(sclk), .busy(busy), .result(result), .result_valid(result_valid),
      .timeout_err(timeout_err));

   // behavioural converter: pin changes 30 time units after each rising edge
   always @(posedge sclk) begin
      dev_idx = dev_idx + 1;
      #30;
      if (dev_idx <= 20) pin = dev_word[20 - dev_idx];
      else               pin = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock monitor: phase widths, rising edges, result strobes
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk != sclk_prev) begin
            if (sclk_prev && busy) chk(ph == HALF, "R2 high phase", 64'(ph), 64'(HALF));
            if (!sclk_prev && low_in_frame) chk(ph == HALF, "R2 low phase", 64'(ph), 64'(HALF));
            if (sclk) rises++;
            low_in_frame = !sclk && busy;
            ph = 1;
         end else begin
            ph++;
         end
         if (!busy) low_in_frame = 1'b0;
         if (result_valid) begin
            got_valid++;
            got_result = result;
         end
      end
      sclk_prev = sclk;
   end

   function automatic logic [OUT_W-1:0] sext(input logic [19:0] w);
      return {{(OUT_W-20){w[19]}}, w};
   endfunction

   task automatic present(input logic [19:0] w);
      dev_word = w;
      dev_idx  = 0;
      pin      = 1'b0;
   endtask

   task automatic issue(input logic [2:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   task automatic run_frame(input logic [2:0] op, input logic [19:0] w, input bit pres);
      rises = 0;
      got_valid = 0;
      if (pres) present(w);
      issue(op);
      wait_idle();
   endtask

   task automatic pulse_mux(input logic [3:0] n);
      @(negedge clk);
      drop_count  = n;
      mux_changed = 1'b1;
      @(negedge clk);
      mux_changed = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(sclk == 0 && busy == 0 && result_valid == 0 && timeout_err == 0, "R11 reset",
          {sclk, busy, result_valid, timeout_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: held off while pin high, then plain 20-pulse read
      rises = 0; got_valid = 0;
      issue(3'd0);
      repeat (30) @(negedge clk);
      chk(rises == 0 && busy, "R1 no clock before ready", 64'(rises), 0);
      present(20'h12345);
      wait_idle();
      chk(rises == 20, "R4 plain read length", 64'(rises), 20);
      chk(got_valid == 1 && got_result == sext(20'h12345), "R3 positive word", got_result, sext(20'h12345));

      // R4/R3: force-high read, negative full scale
      run_frame(3'd1, 20'h80000, 1);
      chk(rises == 21, "R4 force-high length", 64'(rises), 21);
      chk(got_valid == 1 && got_result == sext(20'h80000), "R3 negative word", got_result, sext(20'h80000));
      chk(pin == 1'b1, "R4 pin high after 21st pulse", 64'(pin), 1);

      // R4: 24-pulse read, positive full scale
      run_frame(3'd2, 20'h7FFFF, 1);
      chk(rises == 24, "R4 full read length", 64'(rises), 24);
      chk(got_result == sext(20'h7FFFF), "R3 positive full scale", got_result, sext(20'h7FFFF));

      run_frame(3'd0, 20'hFFFFF, 1);
      chk(got_result == '1, "R3 minus one", got_result, '1);

      // R10: command during a frame is ignored
      rises = 0; got_valid = 0;
      present(20'h0F0F0);
      issue(3'd0);
      repeat (40) @(negedge clk);
      issue(3'd3);
      wait_idle();
      chk(rises == 20 && got_valid == 1, "R10 mid-frame command ignored", 64'(rises), 20);
      chk(got_result == sext(20'h0F0F0), "R10 result intact", got_result, sext(20'h0F0F0));

      // R6: four readings dropped after an input change, fifth reported
      pulse_mux(4'd4);
      for (int k = 0; k < 4; k++) begin
         run_frame(3'd1, 20'(k + 1), 1);
         chk(got_valid == 0, "R6 reading dropped", 64'(got_valid), 0);
      end
      run_frame(3'd1, 20'h00555, 1);
      chk(got_valid == 1 && got_result == sext(20'h00555), "R6 fifth reading reported", got_result, sext(20'h00555));

      // R5/R7: calibration frame waits for ready and clears pending drops
      pulse_mux(4'd4);
      rises = 0; got_valid = 0;
      present(20'h00100);
      issue(3'd3);
      for (int n = 0; n < 3000 && rises < 26; n++) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(rises == 26, "R4 calibration length", 64'(rises), 26);
      chk(busy == 1, "R5 busy until ready after calibration", 64'(busy), 1);
      present(20'h54321);
      repeat (8) @(negedge clk);
      chk(busy == 0 && got_valid == 0, "R5 calibration done without result", {busy, 8'(got_valid)}, 0);
      run_frame(3'd0, 20'h54321, 1);
      chk(got_valid == 1 && got_result == sext(20'h54321), "R7 first read after calibration", got_result, sext(20'h54321));

      // R8/R7: standby park, ignored read, wake
      pulse_mux(4'd4);
      issue(3'd4);
      @(negedge clk);
      chk(sclk == 1 && busy == 0, "R8 parked high", {sclk, busy}, 2);
      rises = 0;
      present(20'h0AAAA);
      issue(3'd0);
      repeat (30) @(negedge clk);
      chk(sclk == 1 && busy == 0 && rises == 0, "R8 read ignored while parked", {sclk, busy}, 2);
      issue(3'd5);
      chk(sclk == 0 && busy == 0, "R8 wake drives clock low", {sclk, busy}, 0);
      run_frame(3'd0, 20'h0ABCD, 1);
      chk(got_valid == 1 && got_result == sext(20'h0ABCD), "R7 first read after wake", got_result, sext(20'h0ABCD));

      // R9: timeout with pin held high, then cleared by the next command
      @(negedge clk);
      pin = 1'b1;
      run_frame(3'd0, 20'h0, 0);
      chk(timeout_err == 1 && rises == 0 && got_valid == 0, "R9 timeout raised", 64'(timeout_err), 1);
      run_frame(3'd0, 20'h00007, 1);
      chk(timeout_err == 0 && got_result == sext(20'h00007), "R9 flag cleared by next read", 64'(timeout_err), 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule